// File: doc/BRIEF.md
# MDIO Management Master Controller

This block is the serial master for station management of Ethernet PHYs. It divides the system clock down to a management clock (MDC), builds read and write management frames, and shifts them out on the data line. The data line is split into a driven value, an output enable and a sampled input, so that the pad logic outside the block forms the bidirectional pin. Each bit the master drives is checked against the pin as it is sampled, so a shorted or contested line raises a fault.

Software sets the block up through one control/status word. It holds the divider, an enable, a switch that suppresses the preamble, a fault-detect enable, a sticky fault flag and a read-only idle indication. A command port starts one transaction, given a read/write selector, a PHY address, a register address and write data. The block pulses a response when the frame completes, and a read returns the 16 data bits captured from the PHY.

Top module: `mdio_master`

## Requirements
- R1: After reset the status word reads 0x1000FF. Its fields are divider = bits 15:0 (0x00FF), enable = bit 16 (0), preamble-off = bit 17 (0), fault-detect enable = bit 18 (0), fault flag = bit 19 (0) and idle = bit 20 (1). MDC is low and the data line is released.
- R2: With a non-zero divider D, MDC has a period of 2*(D+1) system clocks. With D = 0, MDC is held low.
- R3: A command is accepted (`cmd_accept` pulses) only when enable is 1, the controller is idle and the divider is non-zero. In every other case `cmd_reject` pulses and the command has no effect.
- R4: With preamble-off = 0, a write frame is 32 driven ones, then start 01, opcode 01, the PHY address, the register address, turnaround 10 and the 16 data bits. Every field is sent MSB first and every bit is driven.
- R5: With preamble-off = 1, the frame starts directly with the start code and has 32 bits in total.
- R6: A read frame uses opcode 10. The master drives the line through the register address and releases it for the 2 turnaround bits and 16 data bits. The last 16 sampled bits are returned MSB first on `rsp_rdata`. A write returns 0.
- R7: The driven data value changes only when MDC falls. Input bits are sampled when MDC rises.
- R8: The idle bit reads 0 from the cycle after a command is accepted until the frame ends or is aborted.
- R9: Clearing enable during a frame lets that frame complete with its response. Afterwards the controller is idle and rejects commands.
- R10: With fault-detect enable = 1, a driven bit that reads back differently at the rising MDC edge sets the fault flag, returns the controller to idle, releases the line and produces no response.
- R11: With fault-detect enable = 0, a readback mismatch leaves the fault flag clear and the frame completes normally.
- R12: The fault flag is cleared only by a write with bit 19 = 1. Writing 0 there leaves it set.
- R13: `rsp_valid` is a single-cycle pulse, issued once per completed frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Write strobe for the control word |
| csr_wdata | input | 20 | Write data, bits 19:0 of the control word |
| csr_rdata | output | 21 | Current control/status word |
| cmd_valid | input | 1 | Command request, one cycle |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data |
| cmd_accept | output | 1 | Command taken this cycle |
| cmd_reject | output | 1 | Command refused this cycle |
| rsp_valid | output | 1 | Frame completed |
| rsp_rdata | output | 16 | Read data of the completed frame |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value to drive |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Sampled data line |

## Verification
The assertions assume that `mdio_i` is stable around each rising MDC edge. They also assume that the pin echoes the driven value unless a fault is meant, and that the control word is held in reset long enough for every register to leave an unknown value. The stimulus meets these conditions. The bench PHY changes its reply only a nanosecond after a falling MDC edge. The pin echoes `mdio_o` whenever the enable is high, except during the deliberate fault cases. Commands are issued only between frames, apart from the one that is meant to be refused as busy.

// File: rtl/mdio_pkg.sv
`timescale 1ns/100ps
package mdio_pkg;
    localparam int DIV_W    = 16;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 16;
    localparam int PRE_W    = 32;
    localparam int BODY_W   = 4 + 2 * ADDR_W + 2 + DATA_W;
    localparam int FRAME_W  = PRE_W + BODY_W;
    localparam int LEFT_W   = $clog2(FRAME_W + 1);

    localparam int BIT_EN      = DIV_W;
    localparam int BIT_PRE_OFF = DIV_W + 1;
    localparam int BIT_FLT_EN  = DIV_W + 2;
    localparam int BIT_FLT     = DIV_W + 3;
    localparam int BIT_IDLE    = DIV_W + 4;
    localparam int CSR_W       = BIT_IDLE + 1;
    localparam int CSR_WR_W    = BIT_IDLE;

    localparam logic [DIV_W-1:0] DIV_RESET = 16'h00FF;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ARM,
        PH_SHIFT
    } phase_t;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } mgmt_cmd_t;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             enable;
        logic             pre_off;
        logic             flt_en;
    } csr_cfg_t;

    // Frame body after the preamble; released bits of a read carry filler ones.
    function automatic logic [BODY_W-1:0] body_bits(mgmt_cmd_t c);
        logic [1:0]        op;
        logic [1:0]        ta;
        logic [DATA_W-1:0] dat;
        op  = c.rd ? 2'b10 : 2'b01;
        ta  = c.rd ? 2'b11 : 2'b10;
        dat = c.rd ? {DATA_W{1'b1}} : c.wdata;
        return {2'b01, op, c.phy, c.regad, ta, dat};
    endfunction

    // Output-enable pattern matching body_bits.
    function automatic logic [BODY_W-1:0] body_drive(logic rd);
        logic [BODY_W-1:0] m;
        m = '1;
        if (rd) begin
            m[DATA_W+1:0] = '0;
        end
        return m;
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/100ps
module mdio_clkgen
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    output logic             mdc_o,
    output logic             rise_o,
    output logic             fall_o
);
    logic [DIV_W-1:0] cnt_q;
    logic             mdc_q;
    logic             run;
    logic             hit;

    assign run = (div_i != '0);
    assign hit = run && (cnt_q >= div_i);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (hit) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Strobes mark the system-clock edge at which MDC toggles.
    assign rise_o = hit && !mdc_q;
    assign fall_o = hit &&  mdc_q;
    assign mdc_o  = mdc_q;

    AST_DIV_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
        (div_i == '0) |=> !mdc_q); // R2
endmodule

// File: rtl/mdio_frame_fsm.sv
`timescale 1ns/100ps
module mdio_frame_fsm
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go_i,
    input  mgmt_cmd_t         cmd_i,
    input  logic              pre_off_i,
    input  logic              flt_en_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              mdio_i,
    output logic              idle_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              flt_set_o
);
    phase_t             ph_q;
    logic [FRAME_W-1:0] sh_q;
    logic [FRAME_W-1:0] mk_q;
    logic [LEFT_W-1:0]  left_q;
    logic               drv_q;
    logic               oe_q;
    logic               done_q;
    logic               flt_q;
    logic [DATA_W-1:0]  rd_q;
    logic               mismatch;
    logic               last_bit;

    assign mismatch = oe_q && (mdio_i != drv_q);
    assign last_bit = (ph_q == PH_SHIFT) && (left_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            sh_q   <= '0;
            mk_q   <= '0;
            left_q <= '0;
            drv_q  <= 1'b0;
            oe_q   <= 1'b0;
            done_q <= 1'b0;
            flt_q  <= 1'b0;
            rd_q   <= '0;
        end else begin
            done_q <= 1'b0;
            flt_q  <= 1'b0;
            unique case (ph_q)
                PH_IDLE: begin
                    if (go_i) begin
                        if (pre_off_i) begin
                            sh_q   <= {body_bits(cmd_i), {PRE_W{1'b0}}};
                            mk_q   <= {body_drive(cmd_i.rd), {PRE_W{1'b0}}};
                            left_q <= LEFT_W'(BODY_W);
                        end else begin
                            sh_q   <= {{PRE_W{1'b1}}, body_bits(cmd_i)};
                            mk_q   <= {{PRE_W{1'b1}}, body_drive(cmd_i.rd)};
                            left_q <= LEFT_W'(FRAME_W);
                        end
                        rd_q <= '0;
                        ph_q <= PH_ARM;
                    end
                end
                PH_ARM, PH_SHIFT: begin
                    if (fall_i) begin
                        if (last_bit) begin
                            oe_q   <= 1'b0;
                            done_q <= 1'b1;
                            ph_q   <= PH_IDLE;
                        end else begin
                            drv_q  <= sh_q[FRAME_W-1];
                            oe_q   <= mk_q[FRAME_W-1];
                            sh_q   <= sh_q << 1;
                            mk_q   <= mk_q << 1;
                            left_q <= left_q - 1'b1;
                            ph_q   <= PH_SHIFT;
                        end
                    end else if (rise_i && ph_q == PH_SHIFT) begin
                        if (oe_q) begin
                            if (flt_en_i && mismatch) begin
                                flt_q <= 1'b1;
                                oe_q  <= 1'b0;
                                ph_q  <= PH_IDLE;
                            end
                        end else begin
                            rd_q <= {rd_q[DATA_W-2:0], mdio_i};
                        end
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign idle_o    = (ph_q == PH_IDLE);
    assign mdio_o    = drv_q;
    assign mdio_oe_o = oe_q;
    assign done_o    = done_q;
    assign rdata_o   = rd_q;
    assign flt_set_o = flt_q;

    AST_PIN_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(drv_q) |-> $past(fall_i)); // R7
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_IDLE) |-> !oe_q); // R10
    AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        go_i |-> (ph_q == PH_IDLE)); // R3
    AST_NO_DONE_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
        !(done_q && flt_q)); // R10
endmodule

// File: rtl/mdio_csr.sv
`timescale 1ns/100ps
module mdio_csr
    import mdio_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_i,
    input  logic [CSR_WR_W-1:0] wdata_i,
    input  logic                idle_i,
    input  logic                flt_set_i,
    output csr_cfg_t            cfg_o,
    output logic [CSR_W-1:0]    rdata_o
);
    csr_cfg_t cfg_q;
    logic     flt_q;
    logic     flt_clr;

    assign flt_clr = wr_i && wdata_i[BIT_FLT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{div: DIV_RESET, enable: 1'b0, pre_off: 1'b0, flt_en: 1'b0};
            flt_q <= 1'b0;
        end else begin
            if (wr_i) begin
                cfg_q.div     <= wdata_i[DIV_W-1:0];
                cfg_q.enable  <= wdata_i[BIT_EN];
                cfg_q.pre_off <= wdata_i[BIT_PRE_OFF];
                cfg_q.flt_en  <= wdata_i[BIT_FLT_EN];
            end
            // A fault in the same cycle as a clear wins.
            if (flt_set_i) begin
                flt_q <= 1'b1;
            end else if (flt_clr) begin
                flt_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata_o              = '0;
        rdata_o[DIV_W-1:0]   = cfg_q.div;
        rdata_o[BIT_EN]      = cfg_q.enable;
        rdata_o[BIT_PRE_OFF] = cfg_q.pre_off;
        rdata_o[BIT_FLT_EN]  = cfg_q.flt_en;
        rdata_o[BIT_FLT]     = flt_q;
        rdata_o[BIT_IDLE]    = idle_i;
    end

    assign cfg_o = cfg_q;

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flt_q && !flt_clr) |=> flt_q); // R12
    AST_FAULT_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        $rose(flt_q) |-> $past(flt_set_i)); // R10
    AST_FAULT_ONLY_ENABLED: assert property (@(posedge clk) disable iff (rst)
        flt_set_i |-> cfg_q.flt_en); // R11
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/100ps
module mdio_master
    import mdio_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          csr_wr,
    input  logic [mdio_pkg::CSR_WR_W-1:0] csr_wdata,
    output logic [mdio_pkg::CSR_W-1:0]    csr_rdata,
    input  logic                          cmd_valid,
    input  logic                          cmd_read,
    input  logic [mdio_pkg::ADDR_W-1:0]   cmd_phy,
    input  logic [mdio_pkg::ADDR_W-1:0]   cmd_reg,
    input  logic [mdio_pkg::DATA_W-1:0]   cmd_wdata,
    output logic                          cmd_accept,
    output logic                          cmd_reject,
    output logic                          rsp_valid,
    output logic [mdio_pkg::DATA_W-1:0]   rsp_rdata,
    output logic                          mdc,
    output logic                          mdio_o,
    output logic                          mdio_oe,
    input  logic                          mdio_i
);
    csr_cfg_t  cfg;
    mgmt_cmd_t cmd;
    logic      idle;
    logic      rise_stb;
    logic      fall_stb;
    logic      flt_set;
    logic      go;

    assign cmd = '{rd: cmd_read, phy: cmd_phy, regad: cmd_reg, wdata: cmd_wdata};
    assign go         = cmd_valid && cfg.enable && idle && (cfg.div != '0);
    assign cmd_accept = go;
    assign cmd_reject = cmd_valid && !go;

    mdio_csr u_csr (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (csr_wr),
        .wdata_i   (csr_wdata),
        .idle_i    (idle),
        .flt_set_i (flt_set),
        .cfg_o     (cfg),
        .rdata_o   (csr_rdata)
    );

    mdio_clkgen u_clk (
        .clk    (clk),
        .rst    (rst),
        .div_i  (cfg.div),
        .mdc_o  (mdc),
        .rise_o (rise_stb),
        .fall_o (fall_stb)
    );

    mdio_frame_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .go_i      (go),
        .cmd_i     (cmd),
        .pre_off_i (cfg.pre_off),
        .flt_en_i  (cfg.flt_en),
        .rise_i    (rise_stb),
        .fall_i    (fall_stb),
        .mdio_i    (mdio_i),
        .idle_o    (idle),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe),
        .done_o    (rsp_valid),
        .rdata_o   (rsp_rdata),
        .flt_set_o (flt_set)
    );

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R13
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        cmd_accept |=> !csr_rdata[BIT_IDLE]); // R8
endmodule

// File: tb/mdio_master_test.sv
`timescale 1ns/100ps
module mdio_master_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_wr = 1'b0;
    logic [19:0] csr_wdata = '0;
    logic [20:0] csr_rdata;
    logic        cmd_valid = 1'b0;
    logic        cmd_read = 1'b0;
    logic [4:0]  cmd_phy = '0;
    logic [4:0]  cmd_reg = '0;
    logic [15:0] cmd_wdata = '0;
    logic        cmd_accept, cmd_reject, rsp_valid;
    logic [15:0] rsp_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    logic        fault_inj = 1'b0;
    logic        phy_bit = 1'b1;
    logic [17:0] phy_sh = '0;

    int n_cmp = 0;
    int n_bad = 0;
    int n_rsp = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign mdio_i = fault_inj ? ~mdio_o : (mdio_oe ? mdio_o : phy_bit);

    mdio_master uut (
        .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .cmd_valid(cmd_valid), .cmd_read(cmd_read), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
        .cmd_wdata(cmd_wdata), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    typedef struct {
        logic [63:0] val;
        logic [63:0] drv;
        int          len;
        logic [15:0] rdat;
        bit          rd;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic exp_t make_exp(bit rd, logic [4:0] phy, logic [4:0] ra,
                                      logic [15:0] wd, bit pre_off, logic [15:0] rdat);
        exp_t e;
        logic [31:0] body;
        logic [31:0] bdrv;
        body = {2'b01, (rd ? 2'b10 : 2'b01), phy, ra, (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : wd)};
        bdrv = rd ? {14'h3FFF, 18'h0} : 32'hFFFF_FFFF;
        if (pre_off) begin
            e.val = {32'h0, body};
            e.drv = {32'h0, bdrv};
            e.len = 32;
        end else begin
            e.val = {32'hFFFF_FFFF, body};
            e.drv = {32'hFFFF_FFFF, bdrv};
            e.len = 64;
        end
        e.rdat = rdat;
        e.rd   = rd;
        e.tag  = pre_off ? "R5" : (rd ? "R6" : "R4");
        return e;
    endfunction

    // Capture of the line at each rising MDC edge during a frame.
    bit          armed = 0;
    bit          active = 0;
    logic [63:0] cap_val = '0;
    logic [63:0] cap_drv = '0;
    int          cap_len = 0;
    bit          prev_rsp = 0;

    always @(negedge mdc) begin
        #1;
        if (armed && !active && mdio_oe) begin
            active = 1;
            armed  = 0;
        end
        if (active && !mdio_oe) begin
            phy_bit = phy_sh[17];
            phy_sh  = phy_sh << 1;
        end
    end

    always @(posedge mdc) begin
        if (active) begin
            cap_val = {cap_val[62:0], mdio_o};
            cap_drv = {cap_drv[62:0], mdio_oe};
            cap_len++;
        end
    end

    // Monitor: pops the scoreboard on each completed frame.
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            exp_t e;
            n_rsp++;
            check(!prev_rsp, "R13", "response pulse longer than one cycle", 1, 0);
            if (sbq.size() == 0) begin
                check(0, "R13", "response with nothing expected", n_rsp, 0);
            end else begin
                e = sbq.pop_front();
                check(cap_len == e.len, e.tag, "frame length", cap_len, e.len);
                check(cap_drv == e.drv, e.tag, "drive pattern", cap_drv, e.drv);
                check((cap_val & e.drv) == (e.val & e.drv), e.tag, "frame bits",
                      cap_val & e.drv, e.val & e.drv);
                if (e.rd)
                    check(rsp_rdata == e.rdat, "R6", "read data", rsp_rdata, e.rdat);
                else
                    check(rsp_rdata == 16'h0, "R6", "write returns zero", rsp_rdata, 0);
            end
            active = 0;
        end
        prev_rsp = rsp_valid;
    end

    task automatic csr_write(input logic [19:0] d);
        @(negedge clk);
        csr_wr    = 1'b1;
        csr_wdata = d;
        @(negedge clk);
        csr_wr    = 1'b0;
    endtask

    // Driver: issues a command and pushes the expected frame when accepted.
    task automatic send_cmd(input bit rd, input logic [4:0] phy, input logic [4:0] ra,
                            input logic [15:0] wd, input bit pre_off, input logic [15:0] rdat,
                            input bit exp_acc, input bit push, input string req);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_read  = rd;
        cmd_phy   = phy;
        cmd_reg   = ra;
        cmd_wdata = wd;
        #1;
        check(cmd_accept == exp_acc && cmd_reject == !exp_acc, req, "accept/reject",
              {cmd_accept, cmd_reject}, {exp_acc, !exp_acc});
        if (cmd_accept) begin
            if (rd) phy_sh = {2'b10, rdat};
            cap_val = '0;
            cap_drv = '0;
            cap_len = 0;
            armed   = 1;
            if (push) sbq.push_back(make_exp(rd, phy, ra, wd, pre_off, rdat));
        end
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (csr_rdata[20]) break;
        end
    endtask

    task automatic measure_period(input int div);
        realtime t0, t1;
        int cyc;
        @(posedge mdc);
        t0 = $realtime;
        @(posedge mdc);
        t1 = $realtime;
        cyc = int'((t1 - t0) / 5.0);
        check(cyc == 2 * (div + 1), "R2", "MDC period in clocks", cyc, 2 * (div + 1));
    endtask

    initial begin
        int rsp_before;
        bit stuck;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(csr_rdata == 21'h1000FF, "R1", "reset status word", csr_rdata, 21'h1000FF);
        check(!mdc && !mdio_oe, "R1", "reset pins", {mdc, mdio_oe}, 0);

        // Disabled: refused
        send_cmd(0, 5'h01, 5'h02, 16'h1234, 0, 0, 0, 0, "R3");
        check(csr_rdata[20] == 1'b1, "R3", "rejected command leaves idle", csr_rdata[20], 1);

        // Enable with divider 1
        csr_write(20'h1_0001);
        measure_period(1);

        // Write frame with preamble
        send_cmd(0, 5'h15, 5'h0A, 16'hBEEF, 0, 0, 1, 1, "R4");
        check(csr_rdata[20] == 1'b0, "R8", "idle clear while busy", csr_rdata[20], 0);
        send_cmd(0, 5'h03, 5'h04, 16'h5555, 0, 0, 0, 0, "R3");
        wait_idle();

        // Read frame with preamble
        send_cmd(1, 5'h1F, 5'h11, 16'h0, 0, 16'hA5C3, 1, 1, "R6");
        wait_idle();
        send_cmd(1, 5'h00, 5'h1F, 16'h0, 0, 16'h8001, 1, 1, "R6");
        wait_idle();

        // Preamble suppressed
        csr_write(20'h3_0001);
        send_cmd(0, 5'h0C, 5'h13, 16'h0F0F, 1, 0, 1, 1, "R5");
        wait_idle();
        send_cmd(1, 5'h07, 5'h08, 16'h0, 1, 16'h3C96, 1, 1, "R5");
        wait_idle();

        // Larger divider
        csr_write(20'h1_0003);
        measure_period(3);
        send_cmd(0, 5'h09, 5'h05, 16'h7E81, 0, 0, 1, 1, "R4");
        wait_idle();

        // Graceful disable mid-frame
        csr_write(20'h1_0001);
        rsp_before = n_rsp;
        send_cmd(0, 5'h11, 5'h06, 16'hC0DE, 0, 0, 1, 1, "R9");
        repeat (60) @(negedge clk);
        csr_write(20'h0_0001);
        check(csr_rdata[16] == 1'b0 && csr_rdata[20] == 1'b0, "R9", "disabled but still busy",
              {csr_rdata[16], csr_rdata[20]}, 0);
        wait_idle();
        repeat (2) @(negedge clk);
        check(n_rsp == rsp_before + 1, "R9", "frame finished after disable", n_rsp, rsp_before + 1);
        send_cmd(0, 5'h11, 5'h06, 16'h1111, 0, 0, 0, 0, "R9");

        // Divider zero: refused and MDC held low
        csr_write(20'h1_0000);
        send_cmd(0, 5'h01, 5'h01, 16'h1, 0, 0, 0, 0, "R3");
        stuck = 1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (mdc) stuck = 0;
        end
        check(stuck, "R2", "MDC held low with zero divider", !stuck, 0);

        // Mismatch with detection off
        csr_write(20'h1_0001);
        fault_inj = 1'b1;
        send_cmd(0, 5'h02, 5'h03, 16'h4321, 0, 0, 1, 1, "R11");
        wait_idle();
        repeat (2) @(negedge clk);
        check(csr_rdata[19] == 1'b0, "R11", "no fault when detection off", csr_rdata[19], 0);

        // Mismatch with detection on
        csr_write(20'h5_0001);
        rsp_before = n_rsp;
        send_cmd(0, 5'h02, 5'h03, 16'h4321, 0, 0, 1, 0, "R10");
        wait_idle();
        repeat (2) @(negedge clk);
        check(csr_rdata[19] == 1'b1, "R10", "fault flag set", csr_rdata[19], 1);
        check(csr_rdata[20] == 1'b1 && !mdio_oe, "R10", "idle and released after fault",
              {csr_rdata[20], mdio_oe}, 2'b10);
        check(n_rsp == rsp_before, "R10", "no response after fault", n_rsp, rsp_before);
        fault_inj = 1'b0;
        armed  = 0;
        active = 0;

        // Write-1-to-clear
        csr_write(20'h5_0001);
        check(csr_rdata[19] == 1'b1, "R12", "writing 0 keeps fault", csr_rdata[19], 1);
        csr_write(20'hD_0001);
        check(csr_rdata[19] == 1'b0, "R12", "writing 1 clears fault", csr_rdata[19], 0);

        // Normal frame after recovery
        send_cmd(1, 5'h0E, 5'h1B, 16'h0, 0, 16'h6A59, 1, 1, "R6");
        wait_idle();
        repeat (4) @(negedge clk);
        check(sbq.size() == 0, "R13", "all expected frames answered", sbq.size(), 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule